// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter

This block keeps the wall-clock time and calendar date as seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month and two-digit year. A 1 Hz update strobe `tick` moves the whole set forward by one second. The carry ripples through all fields in the same clock cycle, so every field that changes does so on the clock edge that samples the strobe.

Two control bits are read at runtime. `fmt_bin` selects plain binary or packed two-digit BCD for every field. `mode_24h` selects 24-hour hours or 12-hour hours with a PM flag. The block knows the length of each month and applies the every-fourth-year leap rule itself, and it counts year 00 as a leap year. A buffer stage can write all seven fields in one cycle through the parallel load port. The current values appear on registered outputs. Changing a format bit does not convert the stored values, so software must reload every field after such a change.

Top module: `rtc_calendar_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the fields become seconds 0, minutes 0, hours 0, day of week 1, date 1, month 1, year 0.
- R2: When `load` is high at a clock edge, all seven fields take the `ld_*` values on that edge. This holds even when `tick` is high in the same cycle.
- R3: A field changes only on an edge where `tick` or `load` is high. Changing `fmt_bin` or `mode_24h` leaves the stored bytes unchanged.
- R4: With `fmt_bin`=0, each field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. A units digit of 9 carries into the tens digit. Seconds and minutes count 0 to 59, and each one's roll from 59 to 0 advances the next field.
- R5: With `fmt_bin`=1, each field is a plain unsigned binary number, so 9 is followed by 0x0A.
- R6: With `mode_24h`=1, hours count 0 to 23. The roll from 23 to 0 advances the day of week and the date.
- R7: With `mode_24h`=0, bit 7 of the hour byte is PM and bits 6:0 hold 1 to 12 in the order 12, 1, 2, ... 11. The PM bit flips on the step from 11 to 12. Only the step from 11 PM to 12 AM advances the day.
- R8: Day of week counts 1 to 7 and goes from 7 back to 1 on each day advance.
- R9: The date goes back to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February of a non-leap year. Each such roll advances the month.
- R10: A year whose value is divisible by 4, including 00, gives February 29 days. This holds in either encoding.
- R11: The month goes from 12 to 1 and advances the year. The year goes from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| fmt_bin | input | 1 | 1 = binary fields, 0 = packed BCD fields |
| mode_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| load | input | 1 | Parallel load of all fields |
| ld_sec | input | 8 | Seconds value to load |
| ld_min | input | 8 | Minutes value to load |
| ld_hour | input | 8 | Hours value to load |
| ld_dow | input | 8 | Day-of-week value to load |
| ld_date | input | 8 | Day-of-month value to load |
| ld_mon | input | 8 | Month value to load |
| ld_year | input | 8 | Year value to load |
| sec | output | 8 | Current seconds |
| min | output | 8 | Current minutes |
| hour | output | 8 | Current hours |
| dow | output | 8 | Current day of week |
| date | output | 8 | Current day of month |
| mon | output | 8 | Current month |
| year | output | 8 | Current year |

## Verification
Each test loads a full time one second before a boundary and applies one strobe. The starting points are chosen so that the result tells the encodings apart: a units digit of 9 gives 0x10 in BCD but 0x0A in binary. Other starting points place the full ripple from last second of the century back to the start, separating 30-day, 31-day, leap and non-leap month ends. The 12-hour set places the hour at 11 AM, 12 PM and 11 PM, which separates the PM flip from the day carry. Directed steps cover the reset values, a load that arrives together with a strobe, and a format change with no strobe, which must leave the bytes as they were.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned FW = 8;
  typedef logic [FW-1:0] fld_t;

  // encode a small number as binary or packed BCD
  function automatic fld_t enc(input int unsigned n, input logic bin);
    return bin ? fld_t'(n) : fld_t'(((n / 10) << 4) | (n % 10));
  endfunction

  // decode a field to its binary value
  function automatic fld_t dec(input fld_t v, input logic bin);
    return bin ? v : fld_t'({4'd0, v[7:4]} * 8'd10) + fld_t'({4'd0, v[3:0]});
  endfunction

  // add one in the selected encoding
  function automatic fld_t inc(input fld_t v, input logic bin);
    if (!bin && v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + fld_t'(1);
  endfunction
endpackage

// File: rtl/rtc_wrap_field.sv
module rtc_wrap_field
  import rtc_cal_pkg::*;
#(
  parameter int unsigned LO  = 0,
  parameter int unsigned RST = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic bin,
  input  logic step,
  input  logic load,
  input  fld_t ld_val,
  input  fld_t hi_bin,
  output fld_t val,
  output logic wrap
);
  logic at_top;
  assign at_top = (dec(val, bin) == hi_bin);
  assign wrap   = step && at_top;

  always_ff @(posedge clk) begin
    if (rst)       val <= fld_t'(RST);
    else if (load) val <= ld_val;
    else if (step) val <= at_top ? fld_t'(LO) : inc(val, bin);
  end
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bin,
  input  logic m24,
  input  logic step,
  input  logic load,
  input  fld_t ld_val,
  output fld_t val,
  output logic wrap
);
  fld_t hb;
  fld_t nxt;
  logic pm;

  assign pm = val[7];
  assign hb = dec({1'b0, val[6:0]}, bin);

  always_comb begin
    if (m24) begin
      nxt  = (hb == 8'd23) ? 8'h00 : inc(val, bin);
      wrap = step && (hb == 8'd23);
    end else begin
      if (hb == 8'd12)      nxt = {pm, 7'd0} | enc(1, bin);
      else if (hb == 8'd11) nxt = {~pm, 7'd0} | enc(12, bin);
      else                  nxt = {pm, 7'd0} | inc({1'b0, val[6:0]}, bin);
      wrap = step && pm && (hb == 8'd11);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (load) val <= ld_val;
    else if (step) val <= nxt;
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic bin,
  input  fld_t mon,
  input  fld_t year,
  output fld_t days
);
  fld_t mb;
  fld_t yb;
  logic leap;

  assign mb   = dec(mon, bin);
  assign yb   = dec(year, bin);
  assign leap = ((yb % 8'd4) == 8'd0);

  always_comb begin
    case (mb)
      8'd2:                      days = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   days = 8'd30;
      default:                   days = 8'd31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fmt_bin,
  input  logic       mode_24h,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] mon,
  output logic [7:0] year
);
  localparam int unsigned SEC_HI  = 59;
  localparam int unsigned DOW_HI  = 7;
  localparam int unsigned MON_HI  = 12;
  localparam int unsigned YEAR_HI = 99;

  logic c_sec, c_min, c_day, c_date, c_mon, c_dow, c_year;
  fld_t mdays;

  rtc_wrap_field #(.LO(0), .RST(0)) u_sec (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(tick), .load(load),
    .ld_val(ld_sec), .hi_bin(fld_t'(SEC_HI)), .val(sec), .wrap(c_sec));

  rtc_wrap_field #(.LO(0), .RST(0)) u_min (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(c_sec), .load(load),
    .ld_val(ld_min), .hi_bin(fld_t'(SEC_HI)), .val(min), .wrap(c_min));

  rtc_hour_field u_hour (
    .clk(clk), .rst(rst), .bin(fmt_bin), .m24(mode_24h), .step(c_min),
    .load(load), .ld_val(ld_hour), .val(hour), .wrap(c_day));

  rtc_wrap_field #(.LO(1), .RST(1)) u_dow (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(c_day), .load(load),
    .ld_val(ld_dow), .hi_bin(fld_t'(DOW_HI)), .val(dow), .wrap(c_dow));

  rtc_month_len u_mlen (
    .bin(fmt_bin), .mon(mon), .year(year), .days(mdays));

  rtc_wrap_field #(.LO(1), .RST(1)) u_date (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(c_day), .load(load),
    .ld_val(ld_date), .hi_bin(mdays), .val(date), .wrap(c_date));

  rtc_wrap_field #(.LO(1), .RST(1)) u_mon (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(c_date), .load(load),
    .ld_val(ld_mon), .hi_bin(fld_t'(MON_HI)), .val(mon), .wrap(c_mon));

  rtc_wrap_field #(.LO(0), .RST(0)) u_year (
    .clk(clk), .rst(rst), .bin(fmt_bin), .step(c_mon), .load(load),
    .ld_val(ld_year), .hi_bin(fld_t'(YEAR_HI)), .val(year), .wrap(c_year));
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
  import rtc_cal_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       fmt_bin,
  input logic       mode_24h,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_dow,
  input logic [7:0] ld_date,
  input logic [7:0] ld_mon,
  input logic [7:0] ld_year,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dow,
  input logic [7:0] date,
  input logic [7:0] mon,
  input logic [7:0] year
);
  logic min_end;
  assign min_end = tick && !load && sec == enc(59, fmt_bin) && min == enc(59, fmt_bin);

  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec == $past(ld_sec) && min == $past(ld_min) && hour == $past(ld_hour) &&
              dow == $past(ld_dow) && date == $past(ld_date) && mon == $past(ld_mon) &&
              year == $past(ld_year))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow) &&
                          $stable(date) && $stable(mon) && $stable(year))); // R3

  AST_SEC_ROLL: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && sec == enc(59, fmt_bin)) |=> (sec == 8'h00)); // R4

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (rst)
    (min_end && !mode_24h && {1'b0, hour[6:0]} == enc(11, fmt_bin))
      |=> (hour[7] != $past(hour[7]))); // R7

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (min_end && mode_24h && hour == enc(23, fmt_bin) && dow == enc(7, fmt_bin))
      |=> (dow == 8'h01)); // R8
endmodule

bind rtc_calendar_counter rtc_cal_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .fmt_bin(fmt_bin), .mode_24h(mode_24h),
  .load(load), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
  .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
  .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date), .mon(mon),
  .year(year));

// File: tb/sim_rtc_calendar_counter.sv
`timescale 1ns/1ps
module sim_rtc_calendar_counter;
  logic clk = 1'b0;
  logic rst, tick, fmt_bin, mode_24h, load;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_mon, ld_year;
  logic [7:0] sec, min, hour, dow, date, mon, year;
  logic [55:0] obs;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign obs = {sec, min, hour, dow, date, mon, year};

  rtc_calendar_counter u0 (
    .clk(clk), .rst(rst), .tick(tick), .fmt_bin(fmt_bin), .mode_24h(mode_24h),
    .load(load), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
    .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date), .mon(mon),
    .year(year));

  // {fmt_bin, mode_24h, start sec..year, expected sec..year}
  localparam int NV = 17;
  localparam logic [113:0] VEC [NV] = '{
    {1'b0,1'b1, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R11 full ripple BCD
    {1'b0,1'b1, 56'h09_34_12_03_15_06_23, 56'h10_34_12_03_15_06_23}, // R4 BCD digit carry
    {1'b0,1'b1, 56'h59_59_09_03_15_06_23, 56'h00_00_10_03_15_06_23}, // R6 hour 09->10 BCD
    {1'b1,1'b1, 56'h3B_3B_17_02_1C_02_17, 56'h00_00_00_03_01_03_17}, // R9 Feb 28 non-leap bin
    {1'b1,1'b1, 56'h3B_3B_17_02_1C_02_18, 56'h00_00_00_03_1D_02_18}, // R10 Feb 28 leap bin
    {1'b0,1'b1, 56'h59_59_23_05_29_02_00, 56'h00_00_00_06_01_03_00}, // R10 year 00 Feb 29
    {1'b0,1'b1, 56'h59_59_23_05_28_02_96, 56'h00_00_00_06_29_02_96}, // R10 BCD leap 96
    {1'b0,1'b1, 56'h59_59_23_05_28_02_98, 56'h00_00_00_06_01_03_98}, // R9 BCD non-leap 98
    {1'b0,1'b1, 56'h59_59_23_01_30_04_15, 56'h00_00_00_02_01_05_15}, // R9 30-day month
    {1'b0,1'b1, 56'h59_59_23_01_30_05_15, 56'h00_00_00_02_31_05_15}, // R9 31-day month
    {1'b0,1'b0, 56'h59_59_11_04_10_07_20, 56'h00_00_92_04_10_07_20}, // R7 11AM->12PM
    {1'b0,1'b0, 56'h59_59_92_04_10_07_20, 56'h00_00_81_04_10_07_20}, // R7 12PM->1PM
    {1'b0,1'b0, 56'h59_59_91_04_10_07_20, 56'h00_00_12_05_11_07_20}, // R7 11PM->12AM
    {1'b1,1'b0, 56'h3B_3B_8B_07_0A_03_14, 56'h00_00_0C_01_0B_03_14}, // R8 dow wrap bin 12h
    {1'b1,1'b1, 56'h09_00_00_01_01_01_00, 56'h0A_00_00_01_01_01_00}, // R5 binary 9->10
    {1'b1,1'b1, 56'h3B_3B_17_06_1F_0C_63, 56'h00_00_00_07_01_01_00}, // R11 binary year 99
    {1'b0,1'b1, 56'h59_59_23_03_30_09_72, 56'h00_00_00_04_01_10_72}  // R9 Sep 30 BCD
  };

  function automatic string vtag(input int i);
    case (i)
      0, 15:             return "R11";
      1:                 return "R4";
      2:                 return "R6";
      3, 7, 8, 9, 16:    return "R9";
      4, 5, 6:           return "R10";
      10, 11, 12:        return "R7";
      13:                return "R8";
      default:           return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input logic b, input logic m, input logic [55:0] st);
    fmt_bin = b; mode_24h = m;
    {ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_mon, ld_year} = st;
  endtask

  task automatic apply(input logic b, input logic m, input logic [55:0] st);
    @(negedge clk); put(b, m, st); load = 1'b1; tick = 1'b0;
    @(negedge clk); load = 1'b0; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; load = 1'b0;
    put(1'b0, 1'b1, 56'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset values", obs, 56'h00_00_00_01_01_01_00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][113], VEC[i][112], VEC[i][111:56]);
      check(vtag(i), obs, VEC[i][55:0]);
    end

    // R2: load and tick together, load wins
    @(negedge clk); put(1'b0, 1'b1, 56'h30_15_08_02_14_03_21); load = 1'b1; tick = 1'b1;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    check("R2 load beats tick", obs, 56'h30_15_08_02_14_03_21);

    // R3: format change with no tick converts nothing
    @(negedge clk); put(1'b0, 1'b1, 56'h45_45_19_06_25_11_87); load = 1'b1;
    @(negedge clk); load = 1'b0; fmt_bin = 1'b1; mode_24h = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 idle, format switched", obs, 56'h45_45_19_06_25_11_87);

    // R5: now binary, 0x45 steps to 0x46
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R5 binary step", obs, 56'h46_45_19_06_25_11_87);

    // R1: reset again from a loaded state
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset after run", obs, 56'h00_00_00_01_01_01_00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule